// File: doc/BRIEF.md
# Multi-word level interrupt mask controller

This block gathers a configurable number of 32-line groups of level-sensitive interrupt inputs and produces one summary interrupt per processor. Every processor owns a private set of mask words. All of them share one view of the raw input levels. A line raises a processor's summary when its input is high and that processor has the line unmasked. Nothing is latched and nothing is acknowledged: a line stays pending for as long as its source holds it high.

Software reaches the registers through a single 32-bit read/write port. The port carries a processor-select field, so each processor's bank sits in its own copy of the same address window. Inside a window the registers are grouped by kind rather than by word. The group order is raw level, mask readback, mask set, mask clear, and each group holds one register per word. Set and clear are write-one-to-act: a zero bit in the written data leaves the mask bit alone. This lets several agents change single lines without a read-modify-write.

Top module: `l1_irq_aggregator`

## Requirements
- R1: After reset every mask bit of every processor is 1, every summary output is 0 and the read data is 0. While the masks stay all ones, the summaries stay 0 whatever the input levels.
- R2: The register for kind k and word w sits at byte offset (k×N_WORDS + w)×4. Kind 0 is the raw level, 1 is mask readback, 2 is mask set and 3 is mask clear. Address bits [1:0] are ignored.
- R3: Reading a kind-0 register returns the live input levels of word w. Line n maps to word n/32, bit n%32.
- R4: Reading a kind-1 register returns the selected processor's current mask word. Reading a kind-2 or kind-3 register returns 0.
- R5: Writing a kind-2 register sets the selected processor's mask bits where the data is 1 and leaves the other bits unchanged.
- R6: Writing a kind-3 register clears the selected processor's mask bits where the data is 1 and leaves the other bits unchanged.
- R7: Writes to kind-0 registers change no mask. Accesses at or beyond byte offset 16×N_WORDS change nothing and read 0.
- R8: A write changes only the mask of the processor named by `cpu_sel`. The other banks keep their masks.
- R9: `irq_summary[c]` is registered. After each clock edge it equals the OR over all lines of (input AND NOT mask of processor c), taken as those values stood just before that edge.
- R10: The read data is registered. It takes the addressed value at the edge where a read is requested and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_WORDS×32 | Level-sensitive interrupt lines |
| req | input | 1 | Register access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | CPU_W | Processor whose bank is accessed |
| addr | input | ADDR_W | Byte offset within the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_summary | output | N_CPUS | Per-processor summary interrupt |

## Verification
The assertions assume the inputs hold known values from the first clock onward. They also assume `req` is low while reset is held, because the mask and read-data stability checks look back one cycle. The bench keeps to both conditions: it drives every input to zero before releasing reset and changes inputs only on the falling edge. Its randomised phase picks addresses across the whole window, including the unmapped top of it, so the assertions also see writes that must leave every mask untouched.

// File: rtl/l1_irq_pkg.sv
package l1_irq_pkg;
    localparam int unsigned LINE_BITS = 32;
    localparam int unsigned MAX_WORDS = 8;
    localparam int unsigned WIDX_W    = 3;

    typedef enum logic [1:0] {
        KIND_LEVEL = 2'd0,
        KIND_MREAD = 2'd1,
        KIND_MSET  = 2'd2,
        KIND_MCLR  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic              hit;
        reg_kind_e         kind;
        logic [WIDX_W-1:0] word;
    } reg_sel_t;
endpackage

// File: rtl/l1_reg_decode.sv
module l1_reg_decode
    import l1_irq_pkg::*;
#(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int unsigned N_REGS = 4 * N_WORDS;

    always_comb begin
        int unsigned idx;
        idx      = 32'(addr[ADDR_W-1:2]);
        sel.hit  = (idx < N_REGS);
        sel.kind = reg_kind_e'(2'(idx / N_WORDS));
        sel.word = WIDX_W'(idx % N_WORDS);
        if (!sel.hit) begin
            sel.kind = KIND_LEVEL;
            sel.word = '0;
        end
    end
endmodule

// File: rtl/l1_mask_bank.sv
module l1_mask_bank
    import l1_irq_pkg::*;
#(
    parameter int unsigned N_WORDS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en,
    input  logic                           clr_en,
    input  logic [WIDX_W-1:0]              word,
    input  logic [LINE_BITS-1:0]           wdata,
    input  logic [N_WORDS*LINE_BITS-1:0]   irq_in,
    output logic [N_WORDS*LINE_BITS-1:0]   mask,
    output logic                           summary
);
    localparam int unsigned LINES = N_WORDS * LINE_BITS;

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic             summary;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.summary = |(irq_in & ~st_q.mask);
        for (int w = 0; w < int'(N_WORDS); w++) begin
            if (word == WIDX_W'(w)) begin
                if (set_en)
                    st_d.mask[w*LINE_BITS +: LINE_BITS] = st_q.mask[w*LINE_BITS +: LINE_BITS] | wdata;
                else if (clr_en)
                    st_d.mask[w*LINE_BITS +: LINE_BITS] = st_q.mask[w*LINE_BITS +: LINE_BITS] & ~wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask    <= '1;
            st_q.summary <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask    = st_q.mask;
    assign summary = st_q.summary;
endmodule

// File: rtl/l1_irq_aggregator.sv
module l1_irq_aggregator
    import l1_irq_pkg::*;
#(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned N_CPUS  = 2,
    localparam int unsigned LINES  = N_WORDS * LINE_BITS,
    localparam int unsigned ADDR_W = $clog2(N_WORDS * 16),
    localparam int unsigned CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic              req,
    input  logic              we,
    input  logic [CPU_W-1:0]  cpu_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [N_CPUS-1:0] irq_summary
);
    typedef struct packed {
        logic [31:0] rdata;
    } port_t;

    reg_sel_t                  sel;
    logic [N_CPUS*LINES-1:0]   mask_flat;
    port_t                     pt_d, pt_q;

    l1_reg_decode #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar c = 0; c < int'(N_CPUS); c++) begin : g_bank
        logic mine;
        assign mine = req && we && sel.hit && (cpu_sel == CPU_W'(c));

        l1_mask_bank #(.N_WORDS(N_WORDS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (mine && (sel.kind == KIND_MSET)),
            .clr_en  (mine && (sel.kind == KIND_MCLR)),
            .word    (sel.word),
            .wdata   (wdata),
            .irq_in  (irq_in),
            .mask    (mask_flat[c*LINES +: LINES]),
            .summary (irq_summary[c])
        );
    end

    always_comb begin
        logic [LINES-1:0] cpu_mask;
        logic [31:0]      lvl_word;
        logic [31:0]      msk_word;
        logic             cpu_ok;

        cpu_mask = '0;
        cpu_ok   = 1'b0;
        for (int c = 0; c < int'(N_CPUS); c++) begin
            if (cpu_sel == CPU_W'(c)) begin
                cpu_mask = mask_flat[c*LINES +: LINES];
                cpu_ok   = 1'b1;
            end
        end

        lvl_word = '0;
        msk_word = '0;
        for (int w = 0; w < int'(N_WORDS); w++) begin
            if (sel.word == WIDX_W'(w)) begin
                lvl_word = irq_in[w*LINE_BITS +: LINE_BITS];
                msk_word = cpu_mask[w*LINE_BITS +: LINE_BITS];
            end
        end

        pt_d = pt_q;
        if (req && !we) begin
            pt_d.rdata = '0;
            if (sel.hit && cpu_ok) begin
                case (sel.kind)
                    KIND_LEVEL: pt_d.rdata = lvl_word;
                    KIND_MREAD: pt_d.rdata = msk_word;
                    default:    pt_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign rdata = pt_q.rdata;
endmodule

// File: rtl/l1_irq_aggregator_chk.sv
module l1_irq_aggregator_chk #(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned N_CPUS  = 2,
    parameter int unsigned LINES   = 64,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned CPU_W   = 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LINES-1:0]        irq_in,
    input logic                    req,
    input logic                    we,
    input logic [CPU_W-1:0]        cpu_sel,
    input logic [ADDR_W-1:0]       addr,
    input logic [31:0]             rdata,
    input logic [N_CPUS*LINES-1:0] mask_flat,
    input logic [N_CPUS-1:0]       irq_summary
);
    // R1: summaries leave reset low
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_summary == '0));

    // R7: a write aimed at the raw-level group leaves every mask alone
    p_level_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req && we && ((32'(addr) >> 2) < N_WORDS)) |-> $stable(mask_flat));

    // R10: read data only moves after a read request
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req && !we) |-> $stable(rdata));

    for (genvar c = 0; c < int'(N_CPUS); c++) begin : g_cpu
        // R9: registered OR of unmasked lines
        p_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_summary[c] == $past(|(irq_in & ~mask_flat[c*LINES +: LINES])));

        // R8: a bank changes only when written through its own select
        p_bank_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(req && we && (32'(cpu_sel) == c)) |-> $stable(mask_flat[c*LINES +: LINES]));
    end
endmodule

bind l1_irq_aggregator l1_irq_aggregator_chk #(
    .N_WORDS (N_WORDS),
    .N_CPUS  (N_CPUS),
    .LINES   (LINES),
    .ADDR_W  (ADDR_W),
    .CPU_W   (CPU_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .req         (req),
    .we          (we),
    .cpu_sel     (cpu_sel),
    .addr        (addr),
    .rdata       (rdata),
    .mask_flat   (mask_flat),
    .irq_summary (irq_summary)
);

// File: tb/l1_irq_aggregator_tb.sv
module l1_irq_aggregator_tb;
    localparam int NW    = 3;
    localparam int NC    = 2;
    localparam int LN    = NW * 32;
    localparam int AW    = $clog2(NW * 16);
    localparam int CW    = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LN-1:0] irq_in = '0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [CW-1:0] cpu_sel = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] irq_summary;

    always #2.5 clk = ~clk;

    l1_irq_aggregator #(.N_WORDS(NW), .N_CPUS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req(req), .we(we),
        .cpu_sel(cpu_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_summary(irq_summary)
    );

    // behavioural reference state
    logic [LN-1:0] m_mask [NC];
    logic [NC-1:0] m_sum;
    logic [31:0]   m_rdata;
    string         m_tag;
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 0;

    task automatic compare();
        n_checks++;
        if (irq_summary !== m_sum) begin
            n_fail++;
            $display("FAIL %s summary: actual %b expected %b", (m_tag == "R1") ? "R1" : "R9", irq_summary, m_sum);
        end
        n_checks++;
        if (rdata !== m_rdata) begin
            n_fail++;
            $display("FAIL %s rdata: actual %h expected %h", m_tag, rdata, m_rdata);
        end
    endtask

    // one cycle: check the edge just passed, drive, advance the model
    task automatic step(input bit r, input bit w, input int c, input int a,
                        input logic [31:0] d, input logic [LN-1:0] lv, input string tag);
        int idx, k, wd;
        @(negedge clk);
        compare();
        req = r; we = w; cpu_sel = CW'(c); addr = AW'(a); wdata = d; irq_in = lv;
        for (int i = 0; i < NC; i++) m_sum[i] = |(lv & ~m_mask[i]);
        idx = (a % (1 << AW)) >> 2;
        k   = idx / NW;
        wd  = idx % NW;
        if (r && !w) begin
            m_rdata = 32'h0;
            if (idx < 4 * NW) begin
                if (k == 0) m_rdata = lv[wd*32 +: 32];
                else if (k == 1) m_rdata = m_mask[c][wd*32 +: 32];
            end
        end
        if (r && w && idx < 4 * NW) begin
            if (k == 2) m_mask[c][wd*32 +: 32] = m_mask[c][wd*32 +: 32] | d;
            if (k == 3) m_mask[c][wd*32 +: 32] = m_mask[c][wd*32 +: 32] & ~d;
        end
        m_tag = tag;
    endtask

    function automatic int off(input int k, input int w);
        return (k * NW + w) * 4;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [LN-1:0] lv;
        for (int i = 0; i < NC; i++) m_mask[i] = '1;
        m_sum = '0; m_rdata = '0; m_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all masked, lines high, summaries quiet
        lv = '1;
        step(0, 0, 0, 0, 0, lv, "R1");
        step(0, 0, 0, 0, 0, lv, "R1");
        step(1, 0, 0, off(1, 0), 0, lv, "R4");            // R4 mask reads all ones
        step(1, 0, 1, off(1, 2), 0, lv, "R4");
        // R3: raw levels, line 37 -> word 1 bit 5
        lv = '0; lv[37] = 1'b1; lv[70] = 1'b1;
        step(1, 0, 0, off(0, 1), 0, lv, "R3");
        step(1, 0, 1, off(0, 2), 0, lv, "R3");
        step(0, 0, 0, 0, 0, lv, "R10");                   // R10 hold
        // R6: clear cpu0 word1 bit5 -> cpu0 summary rises, cpu1 not (R8)
        step(1, 1, 0, off(3, 1), 32'h0000_0020, lv, "R6");
        step(0, 0, 0, 0, 0, lv, "R9");
        step(0, 0, 0, 0, 0, lv, "R9");
        step(1, 0, 0, off(1, 1), 0, lv, "R6");
        step(1, 0, 1, off(1, 1), 0, lv, "R8");
        // R9: drop the line
        lv[37] = 1'b0;
        step(0, 0, 0, 0, 0, lv, "R9");
        step(0, 0, 0, 0, 0, lv, "R9");
        // R5: set it back
        lv[37] = 1'b1;
        step(1, 1, 0, off(2, 1), 32'h0000_0020, lv, "R5");
        step(1, 0, 0, off(1, 1), 0, lv, "R5");
        step(1, 0, 0, off(2, 1), 0, lv, "R4");            // set reads zero
        step(1, 0, 0, off(3, 0), 0, lv, "R4");            // clear reads zero
        // R7: status write and out-of-range accesses ignored
        step(1, 1, 1, off(0, 2), 32'hFFFF_FFFF, lv, "R7");
        step(1, 0, 1, off(1, 2), 0, lv, "R7");
        step(1, 1, 1, 52, 32'hFFFF_FFFF, lv, "R7");
        step(1, 0, 1, 52, 0, lv, "R7");
        step(1, 0, 1, off(1, 0), 0, lv, "R7");
        // R2: low address bits ignored (clear word 2 bit 6 on cpu1 via offset+3)
        step(1, 1, 1, off(3, 2) + 3, 32'h0000_0040, lv, "R2");
        step(1, 0, 1, off(1, 2) + 1, 0, lv, "R2");
        step(0, 0, 0, 0, 0, lv, "R9");
        // randomised mix
        for (int n = 0; n < 400; n++) begin
            logic [LN-1:0] rl;
            for (int j = 0; j < NW; j++) rl[j*32 +: 32] = $urandom & $urandom;
            step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, NC - 1),
                 $urandom_range(0, (1 << AW) - 1), $urandom, rl, "R9");
        end
        step(0, 0, 0, 0, 0, '0, "R10");
        step(0, 0, 0, 0, 0, '0, "R10");
        @(negedge clk);
        compare();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule